// File: doc/BRIEF.md
# UART data register interface

This block sits between a host bus and the transmit and receive shifter cores of a serial port. One bus address serves two registers. A write to it goes to a transmit holding register that cannot be read back. A read from it returns the receive buffer, which cannot be written. The block keeps the transmit-empty and receive-full flags. It hands one byte at a time to the transmit shifter through a ready/load handshake. It accepts completed frames from the receive shifter as a one-cycle valid pulse.

Frames can be 7 or 8 data bits long. In 7-bit mode the top bit is cleared on both sides, so the receive buffer shows it as 0 and the transmit shifter never sees it. The parity, framing and overrun errors are sticky, and a separate strobe clears them. While any error is set, the buffer is marked invalid and a host read does not clear the receive interrupt. The transmit interrupt follows the transmit-empty flag, gated by its enable.

Top module: `uart_dreg_top`

## Requirements
- R1: During reset and in the cycle after it, tx_empty is 1 and rx_full, all error flags, rx_data_invalid, irq_rx and irq_tx (with cfg_tx_ie 0) are 0.
- R2: A write to DATA_ADDR with cfg_tx_en 1 loads the holding register and makes tx_empty 0 from the next cycle. A read from DATA_ADDR returns the receive buffer on bus_rdata in the same cycle, never the value last written.
- R3: A write while cfg_tx_en is 0 is ignored: tx_empty stays 1 and no tx_load follows.
- R4: While tx_empty is 0 and tx_ready is 1, tx_load is 1 in that cycle with tx_data equal to the held byte, and tx_empty is 1 in the next cycle.
- R5: With cfg_len7 1 at write time, bit 7 of tx_data is 0; with cfg_len7 0 all 8 bits pass unchanged.
- R6: A rx_valid pulse while rx_full is 0 stores rx_data and sets rx_full from the next cycle. With cfg_len7 1, bit 7 of the stored byte is 0.
- R7: A read from DATA_ADDR clears rx_full in the next cycle.
- R8: A rx_valid pulse while rx_full is 1 sets err_overrun and leaves the buffer contents unchanged.
- R9: rx_perr or rx_ferr given with rx_valid (buffer not full) sets err_parity or err_framing. rx_data_invalid is the OR of the three error flags. A err_clr pulse clears them all in the next cycle, except an error that arrives in the same cycle as the strobe, which is kept.
- R10: With cfg_rx_ie 1, a rx_valid pulse sets irq_rx from the next cycle; with cfg_rx_ie 0 it does not. A read from DATA_ADDR clears irq_rx only if no error flag is set at the time of the read.
- R11: irq_tx equals cfg_tx_ie AND tx_empty in every cycle.
- R12: Reads and writes to any address other than DATA_ADDR return 0 on bus_rdata and change neither rx_full nor tx_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, receive buffer when reading DATA_ADDR, else 0 |
| cfg_len7 | input | 1 | 1 selects 7-bit frames |
| cfg_tx_en | input | 1 | Transmit enable, gates writes |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| err_clr | input | 1 | Clears all error flags |
| rx_valid | input | 1 | Frame-complete pulse from receive shifter |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with this frame |
| rx_ferr | input | 1 | Framing error with this frame |
| tx_ready | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | Byte handed to transmit shifter this cycle |
| tx_data | output | 8 | Byte to transmit shifter |
| tx_empty | output | 1 | Holding register free |
| rx_full | output | 1 | Receive buffer holds unread data |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |
| rx_data_invalid | output | 1 | Buffer contents invalid (any error) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
A wrong flag register appears at the ports one cycle after the event that should have moved it. A stuck tx_empty shows up either as a missing tx_load or as an irq_tx that disagrees with its enable. A stuck rx_full turns the next frame into an overrun, which is visible in the following cycle. A wrong 7-bit mask or a lost byte shows on bus_rdata or tx_data in the very cycle of the read or load. Sweeping every byte value in both frame lengths exposes any masked, swapped or stuck data bit. An irq_rx that a read clears despite an error shows up right after that read.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;

    localparam int UART_DW = 8;

    typedef logic [UART_DW-1:0] byte_t;

    typedef enum logic {
        LEN_8 = 1'b0,
        LEN_7 = 1'b1
    } frame_len_e;

    typedef struct packed {
        logic parity;
        logic overrun;
        logic framing;
    } rx_err_t;

    localparam rx_err_t NO_ERR = '{parity: 1'b0, overrun: 1'b0, framing: 1'b0};

    // Clear the top data bit when the frame carries only 7 bits.
    function automatic byte_t fit_len(input byte_t d, input frame_len_e len);
        byte_t r;
        r = d;
        if (len == LEN_7) begin
            r[UART_DW-1] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic any_err(input rx_err_t e);
        return e.parity | e.overrun | e.framing;
    endfunction

endpackage

// File: rtl/uart_dreg_decode.sv
module uart_dreg_decode
    import uart_dreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              tx_en,
    input  byte_t             rx_buf,
    output logic              wr_hit,
    output logic              rd_hit,
    output byte_t             rdata
);

    logic addr_match;

    always_comb begin
        addr_match = (bus_addr == DATA_ADDR);
        wr_hit     = bus_wr & addr_match & tx_en;
        rd_hit     = bus_rd & addr_match;
        rdata      = rd_hit ? rx_buf : '0;
    end

endmodule

// File: rtl/uart_dreg_rx.sv
module uart_dreg_rx
    import uart_dreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  byte_t      rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  frame_len_e len,
    input  logic       rd_hit,
    input  logic       err_clr,
    output byte_t      rx_buf,
    output logic       full,
    output rx_err_t    err
);

    byte_t   buf_q;
    logic    full_q;
    rx_err_t err_q;
    rx_err_t err_d;
    logic    store;

    always_comb begin
        store = rx_valid & ~full_q;
        err_d = err_clr ? NO_ERR : err_q;
        if (rx_valid) begin
            if (full_q) begin
                err_d.overrun = 1'b1;
            end else begin
                err_d.parity  = err_d.parity  | rx_perr;
                err_d.framing = err_d.framing | rx_ferr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            err_q  <= NO_ERR;
        end else begin
            err_q <= err_d;
            if (store) begin
                buf_q  <= fit_len(rx_data, len);
                full_q <= 1'b1;
            end else if (rd_hit) begin
                full_q <= 1'b0;
            end
        end
    end

    assign rx_buf = buf_q;
    assign full   = full_q;
    assign err    = err_q;

endmodule

// File: rtl/uart_dreg_tx.sv
module uart_dreg_tx
    import uart_dreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  byte_t      wdata,
    input  frame_len_e len,
    input  logic       tx_ready,
    output logic       tx_load,
    output byte_t      tx_data,
    output logic       empty
);

    byte_t hold_q;
    logic  empty_q;

    assign tx_load = ~empty_q & tx_ready;
    assign tx_data = hold_q;
    assign empty   = empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_hit) begin
                hold_q  <= fit_len(wdata, len);
                empty_q <= 1'b0;
            end else if (tx_load) begin
                empty_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_dreg_irq.sv
module uart_dreg_irq (
    input  logic clk,
    input  logic rst,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic frame_done,
    input  logic rd_hit,
    input  logic err_any,
    input  logic tx_empty,
    output logic irq_rx,
    output logic irq_tx
);

    logic rx_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_pend_q <= 1'b0;
        end else if (frame_done && rx_ie) begin
            rx_pend_q <= 1'b1;
        end else if (rd_hit && !err_any) begin
            rx_pend_q <= 1'b0;
        end
    end

    assign irq_rx = rx_pend_q;
    assign irq_tx = tx_ie & tx_empty;

endmodule

// File: rtl/uart_dreg_top.sv
module uart_dreg_top
    import uart_dreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cfg_len7,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_ie,
    input  logic              cfg_tx_ie,
    input  logic              err_clr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [7:0]        tx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_framing,
    output logic              rx_data_invalid,
    output logic              irq_rx,
    output logic              irq_tx
);

    frame_len_e len;
    logic       wr_hit;
    logic       rd_hit;
    byte_t      rx_buf;
    rx_err_t    err;

    assign len = cfg_len7 ? LEN_7 : LEN_8;

    uart_dreg_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_ADDR(DATA_ADDR)
    ) u_decode (
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .tx_en   (cfg_tx_en),
        .rx_buf  (rx_buf),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .rdata   (bus_rdata)
    );

    uart_dreg_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_perr (rx_perr),
        .rx_ferr (rx_ferr),
        .len     (len),
        .rd_hit  (rd_hit),
        .err_clr (err_clr),
        .rx_buf  (rx_buf),
        .full    (rx_full),
        .err     (err)
    );

    uart_dreg_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .wdata   (bus_wdata),
        .len     (len),
        .tx_ready(tx_ready),
        .tx_load (tx_load),
        .tx_data (tx_data),
        .empty   (tx_empty)
    );

    uart_dreg_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .rx_ie     (cfg_rx_ie),
        .tx_ie     (cfg_tx_ie),
        .frame_done(rx_valid),
        .rd_hit    (rd_hit),
        .err_any   (any_err(err)),
        .tx_empty  (tx_empty),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    assign err_parity      = err.parity;
    assign err_overrun     = err.overrun;
    assign err_framing     = err.framing;
    assign rx_data_invalid = any_err(err);

endmodule

// File: rtl/uart_dreg_checker.sv
module uart_dreg_checker #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              cfg_tx_en,
    input logic              err_clr,
    input logic              rx_valid,
    input logic              tx_load,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              err_overrun,
    input logic              rx_data_invalid,
    input logic              irq_rx
);

    logic wr_data;
    logic rd_data;

    assign wr_data = bus_wr && (bus_addr == DATA_ADDR) && cfg_tx_en;
    assign rd_data = bus_rd && (bus_addr == DATA_ADDR);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_empty && !rx_full && !rx_data_invalid && !irq_rx));

    a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> !tx_empty);

    a_r3_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !cfg_tx_en && tx_empty) |=> tx_empty);

    a_r4_load_frees: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !wr_data) |=> tx_empty);

    a_r6_frame_fills: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_full) |=> rx_full);

    a_r7_read_empties: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_valid) |=> !rx_full);

    a_r8_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full) |=> err_overrun);

    a_r9_error_clear: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rx_valid) |=> !rx_data_invalid);

    a_r10_irq_kept_on_error: assert property (@(posedge clk) disable iff (rst)
        (rd_data && rx_data_invalid && irq_rx) |=> irq_rx);

endmodule

bind uart_dreg_top uart_dreg_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR)
) u_checker (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .cfg_tx_en      (cfg_tx_en),
    .err_clr        (err_clr),
    .rx_valid       (rx_valid),
    .tx_load        (tx_load),
    .tx_empty       (tx_empty),
    .rx_full        (rx_full),
    .err_overrun    (err_overrun),
    .rx_data_invalid(rx_data_invalid),
    .irq_rx         (irq_rx)
);

// File: tb/test_uart_dreg_top.sv
`timescale 1ns/1ps
module test_uart_dreg_top;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 4'h2;
    localparam logic [ADDR_W-1:0] OTHER_ADDR = 4'h5;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr, bus_rd;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              cfg_len7, cfg_tx_en, cfg_rx_ie, cfg_tx_ie, err_clr;
    logic              rx_valid, rx_perr, rx_ferr, tx_ready;
    logic [7:0]        rx_data, tx_data;
    logic              tx_load, tx_empty, rx_full;
    logic              err_parity, err_overrun, err_framing, rx_data_invalid;
    logic              irq_rx, irq_tx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_dreg_top #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) i_uart_dreg_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_len7(cfg_len7),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_ie(cfg_rx_ie), .cfg_tx_ie(cfg_tx_ie),
        .err_clr(err_clr), .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .tx_ready(tx_ready), .tx_load(tx_load), .tx_data(tx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_framing(err_framing),
        .rx_data_invalid(rx_data_invalid), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic frame(input logic [7:0] v, input logic pe, input logic fe);
        rx_data = v; rx_perr = pe; rx_ferr = fe; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] e;
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        cfg_len7 = 0; cfg_tx_en = 0; cfg_rx_ie = 0; cfg_tx_ie = 0; err_clr = 0;
        rx_valid = 0; rx_perr = 0; rx_ferr = 0; tx_ready = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
        chk(rx_full == 0, "R1 rx_full", rx_full, 0);
        chk({err_parity, err_overrun, err_framing, rx_data_invalid} == 0, "R1 errors",
            {err_parity, err_overrun, err_framing, rx_data_invalid}, 0);
        chk(irq_rx == 0 && irq_tx == 0, "R1 irqs", {irq_rx, irq_tx}, 0);

        // R11 enable gating
        cfg_tx_ie = 1'b1;
        #1 chk(irq_tx == 1, "R11 irq_tx with empty", irq_tx, 1);

        // R3 write while disabled
        bus_write(DATA_ADDR, 8'h55);
        chk(tx_empty == 1, "R3 tx_empty after disabled write", tx_empty, 1);
        tx_ready = 1'b1;
        #1 chk(tx_load == 0, "R3 no tx_load", tx_load, 0);
        @(negedge clk);
        tx_ready = 1'b0;

        cfg_tx_en = 1'b1;
        cfg_rx_ie = 1'b1;

        // R2, R4, R5, R11 transmit sweep
        for (int len = 0; len < 2; len++) begin
            cfg_len7 = len[0];
            for (int v = 0; v < 256; v++) begin
                e = len[0] ? (v[7:0] & 8'h7F) : v[7:0];
                bus_write(DATA_ADDR, v[7:0]);
                chk(tx_empty == 0, "R2 tx_empty after write", tx_empty, 0);
                chk(irq_tx == 0, "R11 irq_tx while full", irq_tx, 0);
                tx_ready = 1'b1;
                #1 chk(tx_load == 1, "R4 tx_load", tx_load, 1);
                chk(tx_data == e, "R5 tx_data", tx_data, e);
                @(negedge clk);
                tx_ready = 1'b0;
                chk(tx_empty == 1, "R4 tx_empty after load", tx_empty, 1);
                chk(irq_tx == 1, "R11 irq_tx after load", irq_tx, 1);
            end
        end

        // R6, R7, R10 receive sweep
        for (int len = 0; len < 2; len++) begin
            cfg_len7 = len[0];
            for (int v = 0; v < 256; v++) begin
                e = len[0] ? (v[7:0] & 8'h7F) : v[7:0];
                frame(v[7:0], 1'b0, 1'b0);
                chk(rx_full == 1, "R6 rx_full", rx_full, 1);
                chk(irq_rx == 1, "R10 irq_rx set", irq_rx, 1);
                bus_read(DATA_ADDR, d);
                chk(d == e, "R6 received byte", d, e);
                chk(rx_full == 0, "R7 rx_full cleared", rx_full, 0);
                chk(irq_rx == 0, "R10 irq_rx cleared", irq_rx, 0);
            end
        end
        cfg_len7 = 1'b0;

        // R2 shared address: read returns receive buffer, not written byte
        bus_write(DATA_ADDR, 8'hA5);
        frame(8'h3C, 1'b0, 1'b0);
        bus_read(DATA_ADDR, d);
        chk(d == 8'h3C, "R2 read returns receive buffer", d, 8'h3C);
        tx_ready = 1'b1;
        #1 chk(tx_data == 8'hA5, "R2 held byte intact", tx_data, 8'hA5);
        @(negedge clk);
        tx_ready = 1'b0;

        // R12 other address
        frame(8'h11, 1'b0, 1'b0);
        bus_read(OTHER_ADDR, d);
        chk(d == 0, "R12 rdata other address", d, 0);
        chk(rx_full == 1, "R12 rx_full kept", rx_full, 1);
        bus_write(OTHER_ADDR, 8'h77);
        chk(tx_empty == 1, "R12 tx_empty kept", tx_empty, 1);
        bus_read(DATA_ADDR, d);
        chk(d == 8'h11, "R12 buffer intact", d, 8'h11);

        // R8 overrun, R10 irq kept under error
        frame(8'h21, 1'b0, 1'b0);
        frame(8'h42, 1'b0, 1'b0);
        chk(err_overrun == 1, "R8 overrun flag", err_overrun, 1);
        chk(rx_data_invalid == 1, "R9 invalid with overrun", rx_data_invalid, 1);
        bus_read(DATA_ADDR, d);
        chk(d == 8'h21, "R8 old byte kept", d, 8'h21);
        chk(irq_rx == 1, "R10 irq_rx kept on error", irq_rx, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err_overrun == 0 && rx_data_invalid == 0, "R9 cleared", {err_overrun, rx_data_invalid}, 0);
        chk(irq_rx == 1, "R10 irq_rx survives clear", irq_rx, 1);
        bus_read(DATA_ADDR, d);
        chk(irq_rx == 0, "R10 irq_rx cleared without error", irq_rx, 0);

        // R9 parity and framing
        frame(8'h10, 1'b1, 1'b0);
        chk(err_parity == 1 && rx_data_invalid == 1, "R9 parity", {err_parity, rx_data_invalid}, 3);
        bus_read(DATA_ADDR, d);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err_parity == 0, "R9 parity cleared", err_parity, 0);
        frame(8'h20, 1'b0, 1'b1);
        chk(err_framing == 1 && err_parity == 0, "R9 framing", {err_framing, err_parity}, 2);
        bus_read(DATA_ADDR, d);
        err_clr = 1'b1;
        frame(8'h30, 1'b1, 1'b0);
        err_clr = 1'b0;
        chk(err_parity == 1 && err_framing == 0, "R9 new error beats clear",
            {err_parity, err_framing}, 2);
        bus_read(DATA_ADDR, d);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        bus_read(DATA_ADDR, d);
        chk(irq_rx == 0, "R10 irq_rx idle", irq_rx, 0);

        // R10 disabled receive interrupt
        cfg_rx_ie = 1'b0;
        frame(8'h5A, 1'b0, 1'b0);
        chk(irq_rx == 0, "R10 irq_rx disabled", irq_rx, 0);
        chk(rx_full == 1, "R6 rx_full with irq disabled", rx_full, 1);
        bus_read(DATA_ADDR, d);
        chk(d == 8'h5A, "R6 byte with irq disabled", d, 8'h5A);

        // R11 enable off
        cfg_tx_ie = 1'b0;
        #1 chk(irq_tx == 0, "R11 irq_tx disabled", irq_tx, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule